// File: doc/BRIEF.md
# Load-Use Dependence Stall Unit

This combinational unit sits beside the decode stage of a five-stage in-order pipeline that has no operand forwarding. Each cycle it compares the source register numbers of the instruction in decode with the destination register numbers of the two older instructions that have not yet written their results back. These older instructions sit in the execute and memory stages. When a live dependence exists, the unit freezes the program counter and the fetch/decode pipeline register, so the dependent instruction waits in decode. In the same cycle it asks the execute-stage control register to load all zeros, so a no-op moves forward in place of the held instruction.

A destination only counts when the older instruction actually writes the register file and its destination is not register 0. A source only counts when the decode instruction really reads that field. A store or branch reads both fields. An immediate-form load reads only its base register. The register file writes in the first half of a cycle and reads in the second half. A producer that has reached writeback therefore never causes a stall. The stall ends by itself in the first cycle with no active match, and instructions ahead of decode keep moving every cycle.

Top module: `hz_load_use_guard`

## Requirements
- R1: When the execute-stage instruction has its write enable at 1 and a nonzero destination equal to a used decode source (first or second), the unit drives `pc_we`=0, `fd_we`=0 and `ex_clr`=1.
- R2: When the memory-stage instruction has its write enable at 1 and a nonzero destination equal to a used decode source, the unit drives `pc_we`=0, `fd_we`=0 and `ex_clr`=1.
- R3: A destination of register 0 never causes a stall, even when it equals a used source.
- R4: An older instruction whose write enable is 0 never causes a stall.
- R5: A source field whose use flag is 0 is ignored. An immediate-form load that reads only its base register (first source) does not stall on its second field.
- R6: When no active match exists, the unit drives `pc_we`=1, `fd_we`=1 and `ex_clr`=0, so the stall releases without any other input.
- R7: `pc_we` and `fd_we` are always equal, and `ex_clr` is always their inverse.
- R8: In a pipeline that advances under these outputs, the number of bubbles depends on how far ahead the producer is. An immediately preceding producer gives two bubbles. A producer two instructions ahead gives one bubble. A producer three instructions ahead, which coincides with writeback, gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_W | First source register number of the decode instruction |
| dec_src_b | input | REG_W | Second source register number of the decode instruction |
| dec_use_a | input | 1 | Decode instruction reads its first source |
| dec_use_b | input | 1 | Decode instruction reads its second source |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes the register file |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes the register file |
| pc_we | output | 1 | Program counter update enable |
| fd_we | output | 1 | Fetch/decode pipeline register load enable |
| ex_clr | output | 1 | Load zero control into the execute stage (bubble) |

## Verification
Two detections can fall in the same cycle. The execute-stage and memory-stage producers can both match, either on one source or with each matching a different source. The bench provokes this with random register numbers drawn from a range of four values, which makes double hits common. It also adds directed cases where both older stages write the same register that both sources read. Each such cycle must produce a single stall with consistent enables, and in the pipelined sequences the total bubble count must stay at two rather than grow.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int NUM_SRC  = 2;
   localparam int NUM_PROD = 2;

   typedef struct packed {
      logic pc_we;
      logic fd_we;
      logic ex_clr;
   } hz_ctl_t;

   localparam hz_ctl_t HZ_RUN  = '{pc_we: 1'b1, fd_we: 1'b1, ex_clr: 1'b0};
   localparam hz_ctl_t HZ_HOLD = '{pc_we: 1'b0, fd_we: 1'b0, ex_clr: 1'b1};
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
   parameter int REG_W       = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic             src_used,
   input  logic [REG_W-1:0] prod_dst,
   input  logic             prod_wen,
   output logic             hit
);
   logic same;
   logic live;

   assign same = (src == prod_dst);

   generate
      if (ZERO_HARDWIRED) begin : g_zero_const
         assign live = prod_wen && (prod_dst != '0);
      end else begin : g_zero_plain
         assign live = prod_wen;
      end
   endgenerate

   assign hit = src_used && live && same;
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
   import hz_pkg::*;
#(
   parameter int N_HITS = 4
) (
   input  logic [N_HITS-1:0] hits,
   output hz_ctl_t           ctl
);
   logic any_hit;

   assign any_hit = |hits;

   always_comb begin
      if (any_hit) ctl = HZ_HOLD;
      else         ctl = HZ_RUN;
   end
endmodule

// File: rtl/hz_load_use_guard.sv
module hz_load_use_guard
   import hz_pkg::*;
#(
   parameter int REG_W          = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic [REG_W-1:0] dec_src_a,
   input  logic [REG_W-1:0] dec_src_b,
   input  logic             dec_use_a,
   input  logic             dec_use_b,
   input  logic [REG_W-1:0] ex_dst,
   input  logic             ex_wen,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wen,
   output logic             pc_we,
   output logic             fd_we,
   output logic             ex_clr
);
   localparam int N_HITS = NUM_SRC * NUM_PROD;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_width
         $error("hz_load_use_guard: REG_W out of supported range");
      end
   endgenerate

   logic [REG_W-1:0] src_v  [NUM_SRC];
   logic             use_v  [NUM_SRC];
   logic [REG_W-1:0] dst_v  [NUM_PROD];
   logic             wen_v  [NUM_PROD];
   logic [N_HITS-1:0] hits;
   hz_ctl_t          ctl;

   assign src_v[0] = dec_src_a;
   assign src_v[1] = dec_src_b;
   assign use_v[0] = dec_use_a;
   assign use_v[1] = dec_use_b;
   assign dst_v[0] = ex_dst;
   assign dst_v[1] = mem_dst;
   assign wen_v[0] = ex_wen;
   assign wen_v[1] = mem_wen;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
            hz_src_match #(
               .REG_W          (REG_W),
               .ZERO_HARDWIRED (ZERO_HARDWIRED)
            ) u_match (
               .src      (src_v[s]),
               .src_used (use_v[s]),
               .prod_dst (dst_v[p]),
               .prod_wen (wen_v[p]),
               .hit      (hits[s*NUM_PROD+p])
            );
         end
      end
   endgenerate

   hz_stall_ctl #(.N_HITS(N_HITS)) u_ctl (
      .hits (hits),
      .ctl  (ctl)
   );

   assign pc_we  = ctl.pc_we;
   assign fd_we  = ctl.fd_we;
   assign ex_clr = ctl.ex_clr;
endmodule

// File: rtl/hz_load_use_guard_chk.sv
module hz_load_use_guard_chk #(
   parameter int REG_W = 5
) (
   input logic [REG_W-1:0] dec_src_a,
   input logic [REG_W-1:0] dec_src_b,
   input logic             dec_use_a,
   input logic             dec_use_b,
   input logic [REG_W-1:0] ex_dst,
   input logic             ex_wen,
   input logic [REG_W-1:0] mem_dst,
   input logic             mem_wen,
   input logic             pc_we,
   input logic             fd_we,
   input logic             ex_clr
);
   logic ex_dep;
   logic mem_dep;

   always_comb begin
      ex_dep  = ex_wen && (ex_dst != '0) &&
                ((dec_use_a && dec_src_a == ex_dst) || (dec_use_b && dec_src_b == ex_dst));
      mem_dep = mem_wen && (mem_dst != '0) &&
                ((dec_use_a && dec_src_a == mem_dst) || (dec_use_b && dec_src_b == mem_dst));
   end

   always_comb begin
      if (ex_dep)
         assert_ex_dep_holds_R1: assert (!pc_we && !fd_we && ex_clr);
      if (mem_dep)
         assert_mem_dep_holds_R2: assert (!pc_we && !fd_we && ex_clr);
      if (!ex_dep && !mem_dep)
         assert_free_runs_R6: assert (pc_we && fd_we && !ex_clr);
      if (ex_dst == '0 && mem_dst == '0)
         assert_zero_dst_quiet_R3: assert (!ex_clr);
      if (!ex_wen && !mem_wen)
         assert_no_writer_quiet_R4: assert (!ex_clr);
      assert_enables_agree_R7: assert (pc_we == fd_we && ex_clr == !pc_we);
   end
endmodule

bind hz_load_use_guard hz_load_use_guard_chk #(.REG_W(REG_W)) u_chk (
   .dec_src_a (dec_src_a),
   .dec_src_b (dec_src_b),
   .dec_use_a (dec_use_a),
   .dec_use_b (dec_use_b),
   .ex_dst    (ex_dst),
   .ex_wen    (ex_wen),
   .mem_dst   (mem_dst),
   .mem_wen   (mem_wen),
   .pc_we     (pc_we),
   .fd_we     (fd_we),
   .ex_clr    (ex_clr)
);

// File: tb/sim_hz_load_use_guard.sv
module sim_hz_load_use_guard;
   localparam int RW = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [RW-1:0] dec_src_a, dec_src_b, ex_dst, mem_dst;
   logic          dec_use_a, dec_use_b, ex_wen, mem_wen;
   logic          pc_we, fd_we, ex_clr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   hz_load_use_guard #(.REG_W(RW)) u0 (
      .dec_src_a (dec_src_a), .dec_src_b (dec_src_b),
      .dec_use_a (dec_use_a), .dec_use_b (dec_use_b),
      .ex_dst (ex_dst), .ex_wen (ex_wen),
      .mem_dst (mem_dst), .mem_wen (mem_wen),
      .pc_we (pc_we), .fd_we (fd_we), .ex_clr (ex_clr)
   );

   typedef struct packed {
      logic [RW-1:0] sa, sb, dst;
      logic          ua, ub, wen;
   } ins_t;

   localparam ins_t NOP = '0;

   function automatic bit dep(input ins_t d, input logic [RW-1:0] dst, input logic wen);
      return wen && dst != 0 && ((d.ua && d.sa == dst) || (d.ub && d.sb == dst));
   endfunction

   function automatic bit exp_hold(input ins_t d, input ins_t e, input ins_t m);
      return dep(d, e.dst, e.wen) || dep(d, m.dst, m.wen);
   endfunction

   task automatic drive(input ins_t d, input ins_t e, input ins_t m);
      dec_src_a = d.sa; dec_src_b = d.sb; dec_use_a = d.ua; dec_use_b = d.ub;
      ex_dst = e.dst; ex_wen = e.wen; mem_dst = m.dst; mem_wen = m.wen;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic apply(input ins_t d, input ins_t e, input ins_t m, input string tag);
      bit h;
      drive(d, e, m);
      @(negedge clk);
      h = exp_hold(d, e, m);
      check({pc_we, fd_we, ex_clr} == (h ? 3'b001 : 3'b110), tag,
            {pc_we, fd_we, ex_clr}, h ? 3'b001 : 3'b110);
      check(pc_we == fd_we && ex_clr == !pc_we, "R7 enables agree", {pc_we, fd_we, ex_clr}, 0);
   endtask

   function automatic ins_t mk(input int sa, input int sb, input bit ua, input bit ub,
                               input int dst, input bit wen);
      ins_t i;
      i.sa = RW'(sa); i.sb = RW'(sb); i.ua = ua; i.ub = ub; i.dst = RW'(dst); i.wen = wen;
      return i;
   endfunction

   // pipeline model: producer writes r5, consumer reads r5 'gap' instructions later
   task automatic run_seq(input int gap, input bit via_b, input int exp_bub, input string tag);
      ins_t prog [8];
      ins_t de, ex, mem;
      int pc, bub;
      for (int k = 0; k < 8; k++) prog[k] = mk(20, 21, 1'b0, 1'b0, 10 + k, 1'b1);
      prog[0] = mk(0, 0, 1'b0, 1'b0, 5, 1'b1);
      prog[gap] = via_b ? mk(7, 5, 1'b1, 1'b1, 12, 1'b1) : mk(5, 0, 1'b1, 1'b0, 12, 1'b1);
      de = prog[0]; ex = NOP; mem = NOP; pc = 1; bub = 0;
      for (int c = 0; c < 12; c++) begin
         drive(de, ex, mem);
         @(negedge clk);
         mem = ex;
         if (ex_clr) begin
            ex = NOP;
            bub++;
         end else begin
            ex = de;
            de = (pc < 8) ? prog[pc] : NOP;
            pc++;
         end
      end
      check(bub == exp_bub, tag, bub, exp_bub);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      // idle pipeline: all bubbles, no stall (R6)
      apply(NOP, NOP, NOP, "R6 idle pipeline runs");
      // directed
      apply(mk(3, 0, 1, 0, 0, 0), mk(0, 0, 0, 0, 3, 1), NOP, "R1 ex hit on first source");
      apply(mk(0, 4, 0, 1, 0, 0), mk(0, 0, 0, 0, 4, 1), NOP, "R1 ex hit on second source");
      apply(mk(6, 0, 1, 0, 0, 0), NOP, mk(0, 0, 0, 0, 6, 1), "R2 mem hit on first source");
      apply(mk(1, 6, 1, 1, 0, 0), NOP, mk(0, 0, 0, 0, 6, 1), "R2 mem hit on second source");
      apply(mk(0, 0, 1, 1, 0, 0), mk(0, 0, 0, 0, 0, 1), mk(0, 0, 0, 0, 0, 1), "R3 register 0 ignored");
      apply(mk(9, 9, 1, 1, 0, 0), mk(0, 0, 0, 0, 9, 0), mk(0, 0, 0, 0, 9, 0), "R4 write enable low ignored");
      apply(mk(2, 8, 1, 0, 0, 0), mk(0, 0, 0, 0, 8, 1), mk(0, 0, 0, 0, 8, 1), "R5 unused second field ignored");
      apply(mk(8, 2, 0, 1, 0, 0), mk(0, 0, 0, 0, 8, 1), NOP, "R5 unused first field ignored");
      apply(mk(11, 11, 1, 1, 0, 0), mk(0, 0, 0, 0, 11, 1), mk(0, 0, 0, 0, 11, 1), "R1 R2 both stages same register");
      apply(mk(13, 14, 1, 1, 0, 0), mk(0, 0, 0, 0, 14, 1), mk(0, 0, 0, 0, 13, 1), "R1 R2 each source other stage");
      apply(mk(13, 14, 1, 1, 0, 0), mk(0, 0, 0, 0, 15, 1), mk(0, 0, 0, 0, 16, 1), "R6 release no match");
      // random, narrow register range to provoke coincident hits
      for (int n = 0; n < 400; n++) begin
         ins_t d, e, m;
         d = mk($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom), 1'($urandom), 0, 0);
         e = mk(0, 0, 0, 0, $urandom_range(0, 3), 1'($urandom));
         m = mk(0, 0, 0, 0, $urandom_range(0, 3), 1'($urandom));
         apply(d, e, m, "R1 R2 R3 R4 R5 R6 random");
      end
      // bubble counts in a moving pipeline
      run_seq(1, 1'b0, 2, "R8 adjacent producer two bubbles");
      run_seq(2, 1'b0, 1, "R8 producer two ahead one bubble");
      run_seq(3, 1'b0, 0, "R8 producer at writeback no bubble");
      run_seq(1, 1'b1, 2, "R8 adjacent producer via second source");
      run_seq(2, 1'b1, 1, "R8 two ahead via second source");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule